// File: doc/BRIEF.md
# Programmable Signal Sense Matcher

This block watches a wide vector of input signals and compares it, on every clock, against a pattern held in a bank of 32-bit configuration words. Each input has its own 2-bit select code. The code either ties the input's contribution to a constant, or makes the contribution true when the input is 0 or when it is 1. All contributions are reduced twice, once by AND and once by OR. Both results are registered and presented as two match outputs.

The AND result is used as an exact pattern match. Inputs that do not matter are tied high, so only the chosen inputs decide the result. The OR result is used as an any-event detector. Inputs that do not matter are tied low, so any chosen input that becomes true raises it. A single bank of words can drive both uses at once. Each word covers eight inputs, and enough consecutive words are provided for the parameterised input count (140 by default).

Top module: `ssm_matcher`

## Requirements
- R1: Input i is controlled by the select code at bits [4k+1:4k] of configuration word w, where w = i / 8 and k = i % 8. Word w occupies `cfg_words[32w+31:32w]`.
- R2: Code 11 makes an input's contribution true when the input is 1. Code 10 makes it true when the input is 0.
- R3: Code 00 makes an input's contribution 0. The input then has no effect on the OR result and forces the AND result to 0. When every input uses code 00, both outputs are 0.
- R4: Code 01 makes an input's contribution 1. The input then has no effect on the AND result and forces the OR result to 1. When every input uses code 01, both outputs are 1.
- R5: `and_match` is the AND of all per-input contributions, and `or_match` is the OR of them. As a result, `and_match` high implies `or_match` high.
- R6: Bits [4k+3:4k+2] of every word, and the code bits of lane slots at or beyond NUM_INPUTS, have no effect on either output.
- R7: Each output shows the result for the inputs and configuration sampled at the previous rising clock edge. It does not change between edges, and it holds its value while the inputs are unchanged.
- R8: When `rst_n` is low at a rising edge, both outputs are 0 after that edge, whatever the inputs are.
- R9: With word 0 = 0x11113232 and every other lane at code 01, `and_match` is 1 exactly when inputs [3:0] equal 4'b1010. With word 0 = 0x11113233, it is 1 exactly when they equal 4'b1011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_words | input | 32*ceil(NUM_INPUTS/8) | Bank of configuration words, with word 0 in the low 32 bits |
| sig_in | input | NUM_INPUTS | Sensed input signals |
| and_match | output | 1 | Registered AND reduction of all contributions |
| or_match | output | 1 | Registered OR reduction of all contributions |

## Verification
Some properties are checked on every cycle. These are: reset clearing both outputs, the AND result never being high while the OR result is low, both outputs holding while the inputs are unchanged, and the fixed outcomes of a bank tied entirely low or entirely high. Other behaviour is shown only by the bench's scenarios. This covers the mapping of each input to its nibble, the polarity of the two sensing codes, the one-cycle latency, the immunity to spare bits, and the two worked pattern examples. The bench sweeps every input value of a 12-input instance under many configurations and compares against an arithmetic model.

// File: rtl/ssm_pkg.sv
// Package: shared constants and the select-code encoding of the matcher.
// Assumes 32-bit configuration words holding eight 4-bit lane fields.
package ssm_pkg;
    localparam int WORD_W         = 32;
    localparam int FIELD_W        = 4;
    localparam int CODE_W         = 2;
    localparam int LANES_PER_WORD = WORD_W / FIELD_W;

    typedef enum logic [CODE_W-1:0] {
        SEL_TIE_LO   = 2'b00,
        SEL_TIE_HI   = 2'b01,
        SEL_SENSE_LO = 2'b10,
        SEL_SENSE_HI = 2'b11
    } sel_code_e;
endpackage

// File: rtl/ssm_cfg_unpack.sv
// Module: picks the 2-bit select code of each input out of the bank of
// configuration words. Assumes lane k of word w controls input 8w+k.
// The upper two bits of each nibble and the lane slots past NUM_INPUTS are
// spare and are folded into a sink so that they are deliberately unused.
module ssm_cfg_unpack
    import ssm_pkg::*;
#(
    parameter int NUM_INPUTS = 140,
    localparam int NUM_WORDS = (NUM_INPUTS + LANES_PER_WORD - 1) / LANES_PER_WORD,
    localparam int CFG_W     = NUM_WORDS * WORD_W
) (
    input  logic [CFG_W-1:0]                 cfg_words,
    output logic [NUM_INPUTS-1:0][CODE_W-1:0] lane_codes
);
    // Builds the mask of configuration bits that never reach a lane.
    function automatic logic [CFG_W-1:0] spare_mask_f();
        logic [CFG_W-1:0] m;
        m = '1;
        for (int s = 0; s < NUM_INPUTS; s++) begin
            m[(s / LANES_PER_WORD) * WORD_W + (s % LANES_PER_WORD) * FIELD_W]     = 1'b0;
            m[(s / LANES_PER_WORD) * WORD_W + (s % LANES_PER_WORD) * FIELD_W + 1] = 1'b0;
        end
        return m;
    endfunction

    localparam logic [CFG_W-1:0] SPARE_MASK = spare_mask_f();

    // Route each lane's code field to its input position.
    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_lane
        localparam int BASE = (i / LANES_PER_WORD) * WORD_W + (i % LANES_PER_WORD) * FIELD_W;
        assign lane_codes[i] = cfg_words[BASE +: CODE_W];
    end

    // Sink the spare bits; they carry no function.
    logic unused_spare;
    assign unused_spare = ^(cfg_words & SPARE_MASK);
endmodule

// File: rtl/ssm_lane_sense.sv
// Module: turns one input and its select code into a single contribution
// bit that both reduction trees share. Assumes the encoding of
// ssm_pkg::sel_code_e: tie low, tie high, sense 0, sense 1.
module ssm_lane_sense
    import ssm_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              sig,
    output logic              contrib
);
    // Decode the select code against the live input.
    always_comb begin
        case (sel_code_e'(code))
            SEL_TIE_LO:   contrib = 1'b0;
            SEL_TIE_HI:   contrib = 1'b1;
            SEL_SENSE_LO: contrib = ~sig;
            default:      contrib = sig;
        endcase
    end
endmodule

// File: rtl/ssm_reduce_tree.sv
// Module: balanced binary reduction of N bits by AND (IS_AND=1) or by OR.
// Assumes N >= 1. Leaves are padded to a power of two with the neutral
// value of the chosen operator, so the depth is ceil(log2(N)) gate levels.
module ssm_reduce_tree #(
    parameter int N      = 140,
    parameter bit IS_AND = 1'b1,
    localparam int DEPTH = (N > 1) ? $clog2(N) : 0,
    localparam int PAD   = 1 << DEPTH
) (
    input  logic [N-1:0] leaves,
    output logic         root
);
    localparam logic NEUTRAL = IS_AND;

    for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
        localparam int W = PAD >> l;
        logic [W-1:0] v;
        if (l == 0) begin : g_leaf
            // Load real leaves, pad the rest with the neutral value.
            for (genvar j = 0; j < W; j++) begin : g_pad
                if (j < N) begin : g_real
                    assign v[j] = leaves[j];
                end else begin : g_fill
                    assign v[j] = NEUTRAL;
                end
            end
        end else begin : g_node
            // Combine pairs from the level below.
            for (genvar j = 0; j < W; j++) begin : g_pair
                if (IS_AND) begin : g_and
                    assign v[j] = g_lvl[l-1].v[2*j] & g_lvl[l-1].v[2*j+1];
                end else begin : g_or
                    assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
                end
            end
        end
    end

    assign root = g_lvl[DEPTH].v[0];
endmodule

// File: rtl/ssm_matcher.sv
// Module: top of the programmable signal sense matcher. Unpacks the lane
// codes, senses every input, reduces the contributions by AND and by OR and
// registers both results. Assumes synchronous active-low reset and one
// cycle from input sample to output.
module ssm_matcher
    import ssm_pkg::*;
#(
    parameter int NUM_INPUTS = 140,
    localparam int NUM_WORDS = (NUM_INPUTS + LANES_PER_WORD - 1) / LANES_PER_WORD,
    localparam int CFG_W     = NUM_WORDS * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CFG_W-1:0]      cfg_words,
    input  logic [NUM_INPUTS-1:0] sig_in,
    output logic                  and_match,
    output logic                  or_match
);
    logic [NUM_INPUTS-1:0][CODE_W-1:0] lane_codes;
    logic [NUM_INPUTS-1:0]             contrib;
    logic                              and_d;
    logic                              or_d;

    ssm_cfg_unpack #(.NUM_INPUTS(NUM_INPUTS)) u_unpack (
        .cfg_words  (cfg_words),
        .lane_codes (lane_codes)
    );

    for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_sense
        ssm_lane_sense u_lane (
            .code    (lane_codes[i]),
            .sig     (sig_in[i]),
            .contrib (contrib[i])
        );
    end

    ssm_reduce_tree #(.N(NUM_INPUTS), .IS_AND(1'b1)) u_and_tree (
        .leaves (contrib),
        .root   (and_d)
    );

    ssm_reduce_tree #(.N(NUM_INPUTS), .IS_AND(1'b0)) u_or_tree (
        .leaves (contrib),
        .root   (or_d)
    );

    // Register both reductions; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_match <= 1'b0;
            or_match  <= 1'b0;
        end else begin
            and_match <= and_d;
            or_match  <= or_d;
        end
    end

    // Masks of the low and high code bits of every live lane.
    function automatic logic [CFG_W-1:0] code_mask_f(input int ofs);
        logic [CFG_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_INPUTS; s++) begin
            m[(s / LANES_PER_WORD) * WORD_W + (s % LANES_PER_WORD) * FIELD_W + ofs] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [CFG_W-1:0] LO_MASK   = code_mask_f(0);
    localparam logic [CFG_W-1:0] CODE_MASK = code_mask_f(0) | code_mask_f(1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!and_match && !or_match)); // R8

    AST_AND_IMPLIES_OR: assert property (@(posedge clk) disable iff (!rst_n)
        and_match |-> or_match); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(cfg_words) && $stable(sig_in))
        |=> ($stable(and_match) && $stable(or_match))); // R7

    AST_ALL_TIE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_words & CODE_MASK) == '0) |=> (!and_match && !or_match)); // R3

    AST_ALL_TIE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_words & CODE_MASK) == LO_MASK) |=> (and_match && or_match)); // R4
endmodule

// File: tb/ssm_matcher_tb.sv
// Bench: 12-input matcher (two words, the second half used) driven at the
// falling edge and sampled at the next falling edge.
module ssm_matcher_tb;
    localparam int N  = 12;
    localparam int NW = (N + 7) / 8;
    localparam int CW = NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg = '0;
    logic [N-1:0]  sig = '0;
    logic          and_o;
    logic          or_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ssm_matcher #(.NUM_INPUTS(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_words (cfg),
        .sig_in    (sig),
        .and_match (and_o),
        .or_match  (or_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=%0d cycles expected<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // Model from the requirements: codes 00/01 tie 0/1, 10 senses 0, 11 senses 1.
    function automatic logic [1:0] model(input logic [CW-1:0] c, input logic [N-1:0] s);
        logic a, o, v;
        logic [1:0] code;
        a = 1'b1;
        o = 1'b0;
        for (int i = 0; i < N; i++) begin
            code = c[(i / 8) * 32 + (i % 8) * 4 +: 2];
            case (code)
                2'b00: v = 1'b0;
                2'b01: v = 1'b1;
                2'b10: v = ~s[i];
                default: v = s[i];
            endcase
            a = a & v;
            o = o | v;
        end
        return {a, o};
    endfunction

    function automatic logic [CW-1:0] fill(input logic [1:0] code);
        logic [CW-1:0] c;
        c = '0;
        for (int i = 0; i < N; i++) c[(i / 8) * 32 + (i % 8) * 4 +: 2] = code;
        return c;
    endfunction

    function automatic logic [CW-1:0] put(input logic [CW-1:0] c0, input int i, input logic [1:0] code);
        logic [CW-1:0] c;
        c = c0;
        c[(i / 8) * 32 + (i % 8) * 4 +: 2] = code;
        return c;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b cfg=%h sig=%h", tag, act, exp, cfg, sig);
        end
    endtask

    // Drive at a falling edge, result visible at the following falling edge.
    task automatic step(input logic [CW-1:0] c, input logic [N-1:0] s);
        @(negedge clk);
        cfg = c;
        sig = s;
        @(negedge clk);
    endtask

    task automatic step_model(input string tag, input logic [CW-1:0] c, input logic [N-1:0] s);
        logic [1:0] e;
        step(c, s);
        e = model(c, s);
        chk(tag, and_o, e[1]);
        chk(tag, or_o, e[0]);
    endtask

    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
    logic [CW-1:0] spare;

    initial begin
        // R8: reset holds outputs low though the inputs would give 1.
        cfg = fill(2'b01);
        sig = '0;
        repeat (3) @(negedge clk);
        chk("R8 reset and", and_o, 1'b0);
        chk("R8 reset or", or_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 all tie-high and", and_o, 1'b1);
        chk("R4 all tie-high or", or_o, 1'b1);

        // R7: no change before the edge, new value after it.
        @(negedge clk);
        cfg = fill(2'b00);
        #1;
        chk("R7 held before edge", and_o, 1'b1);
        @(negedge clk);
        chk("R3 all tie-low and", and_o, 1'b0);
        chk("R3 all tie-low or", or_o, 1'b0);
        @(negedge clk);
        chk("R7 holds while stable", or_o, 1'b0);

        // R8: reset in mid-run clears outputs.
        step(fill(2'b01), '0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid-run and", and_o, 1'b0);
        chk("R8 mid-run or", or_o, 1'b0);
        rst_n = 1'b1;

        // R1/R2: one sensing lane at a time, others neutral for the reduction under test.
        for (int j = 0; j < N; j++) begin
            step(put(fill(2'b01), j, 2'b11), N'(1) << j);
            chk("R1 R2 sense-1 hit", and_o, 1'b1);
            step(put(fill(2'b01), j, 2'b11), ~(N'(1) << j));
            chk("R1 R2 sense-1 miss", and_o, 1'b0);
            step(put(fill(2'b00), j, 2'b10), ~(N'(1) << j));
            chk("R1 R2 sense-0 hit", or_o, 1'b1);
            step(put(fill(2'b00), j, 2'b10), N'(1) << j);
            chk("R1 R2 sense-0 miss", or_o, 1'b0);
            // R3/R4: a single tie code dominates the other reduction.
            step(put(fill(2'b11), j, 2'b00), '1);
            chk("R3 one tie-low forces and", and_o, 1'b0);
            chk("R3 tie-low neutral in or", or_o, 1'b1);
            step(put(fill(2'b11), j, 2'b01), '0);
            chk("R4 one tie-high forces or", or_o, 1'b1);
            chk("R4 tie-high neutral in and", and_o, 1'b0);
        end

        // R6: spare bits flipped give the same result as spare bits clear.
        spare = ~(fill(2'b11));
        for (int t = 0; t < 64; t++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            step_model("R6 spare set", (CW'(lfsr) & ~spare) | spare, N'(lfsr >> 20));
            step_model("R6 spare clear", CW'(lfsr) & ~spare, N'(lfsr >> 20));
        end

        // R9: the two worked examples over every input value.
        for (int s = 0; s < (1 << N); s++) begin
            step({32'h0000_1111, 32'h1111_3232}, N'(s));
            chk("R9 pattern 1010", and_o, (s[3:0] == 4'b1010));
        end
        for (int s = 0; s < (1 << N); s++) begin
            step({32'h0000_1111, 32'h1111_3233}, N'(s));
            chk("R9 pattern 1011", and_o, (s[3:0] == 4'b1011));
        end

        // R5: exhaustive input sweep under pseudo-random configurations.
        for (int k = 0; k < 10; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            for (int s = 0; s < (1 << N); s++) begin
                step_model("R5 sweep", CW'(lfsr), N'(s));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule